// File: doc/BRIEF.md
# Serial-Access Seconds and Subsecond Time Counter

This block keeps a running time value made of a 32-bit whole-seconds field above an 8-bit fraction-of-a-second field. A one-cycle pulse, which a clock divider elsewhere produces at 256 Hz, advances the fraction field. When the fraction field wraps, the seconds field advances. Counting runs only while a run-enable input is high. Serial reads and writes never pause it.

Software reaches the counter over a four-wire serial link: an active-low select, a serial clock, data in and data out. All four are sampled in the system clock domain. A command decoder upstream tells the block, with a one-cycle strobe, whether the burst now open is a read or a write.

- **Writes:** a write shifts in a full 40-bit word and commits it in one step. A write cut short leaves the counter untouched.
- **Reads:** a read freezes a copy of the counter when the strobe arrives and shifts that copy out. A value that is still counting is therefore never returned half-updated.

Top module: `serial_time_counter`

## Requirements
- R1: After a synchronous reset, `time_o` is all zeros and `sdo_o` is 0.
- R2: While `run_en_i` is 1, each `tick_i` pulse adds one to the 40-bit value. The fraction field is bits 7..0 and the seconds field is bits 39..8. Fraction 0xFF rolls to 0x00 and carries into the seconds field. All-ones rolls to all zeros.
- R3: While `run_en_i` is 0, `tick_i` pulses leave `time_o` unchanged.
- R4: A write strobe is `cmd_valid_i`=1 with `cmd_write_i`=1. A write commits only if `wr_en_i` is 1 at its 40th rising serial clock edge. Otherwise the shifted data is discarded and `time_o` keeps its value.
- R5: Write data is taken on rising serial clock edges, bit 39 (seconds MSB) first and bit 0 (fraction LSB) last. The whole value replaces the counter on the 40th rising edge.
- R6: If select goes high (`cs_n_i`=1) before the 40th rising edge, `time_o` keeps its value. The next burst again starts at bit 39.
- R7: A read strobe is `cmd_valid_i`=1 with `cmd_write_i`=0. It copies the counter into a snapshot, and `sdo_o` at once shows bit 39 of that copy. Each falling serial clock edge then moves `sdo_o` to the next lower bit. All 40 bits read back equal the snapshot, even if the counter advances meanwhile.
- R8: Raising select during a read ends it. The bits already delivered match the snapshot, `sdo_o` returns to 0, and `time_o` is unaffected.
- R9: If a tick lands in the same cycle as a write commit, the written value is stored and that tick is lost.
- R10: Ticks during an open read or write burst still advance `time_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle advance pulse (256 Hz rate) |
| run_en_i | input | 1 | Counting enable |
| wr_en_i | input | 1 | Write permission |
| cs_n_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial data in |
| cmd_valid_i | input | 1 | One-cycle burst command strobe |
| cmd_write_i | input | 1 | Burst kind with the strobe: 1 write, 0 read |
| time_o | output | 40 | Current counter value, seconds in 39..8 |
| sdo_o | output | 1 | Serial data out |

## Verification
The bench builds the block with its defaults: 32 seconds bits, 8 fraction bits and a two-stage synchronizer. The time value can be written, so the bench preloads fraction 0xFF and all-ones. A single tick then reaches the fraction carry and the full rollover, which free counting would take years to reach. The serial clock is driven slowly enough that synchronizer delay is known exactly. This lets one directed case place a tick on the very cycle of a write commit. Other cases put ticks inside open bursts.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  typedef enum logic [1:0] {
    BURST_READ  = 2'b01,
    BURST_WRITE = 2'b10
  } burst_kind_e;

  function automatic burst_kind_e kind_of(input logic is_write);
    return is_write ? BURST_WRITE : BURST_READ;
  endfunction
endpackage

// File: rtl/rtcs_sync.sv
module rtcs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rtcs_counter.sv
module rtcs_counter #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 8,
  localparam int TOT_W = SEC_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             tick,
  input  logic             load,
  input  logic [TOT_W-1:0] load_val,
  output logic [TOT_W-1:0] value
);
  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic             sub_wrap;

  assign sub_wrap = &sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (load) begin
      sec_q <= load_val[TOT_W-1:SUB_W];
      sub_q <= load_val[SUB_W-1:0];
    end else if (run_en && tick) begin
      sub_q <= sub_q + SUB_W'(1);
      if (sub_wrap) sec_q <= sec_q + SEC_W'(1);
    end
  end

  assign value = {sec_q, sub_q};
endmodule

// File: rtl/rtcs_shift_in.sv
module rtcs_shift_in #(
  parameter int TOT_W = 40,
  localparam int CNT_W = $clog2(TOT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             arm,
  input  logic             sck_rise,
  input  logic             sdi,
  input  logic             wr_en,
  output logic             commit,
  output logic [TOT_W-1:0] commit_val
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOT_W - 1);

  logic [TOT_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             last_edge;

  assign last_edge  = sel && armed && sck_rise && (cnt == LAST);
  assign commit     = last_edge && wr_en;
  assign commit_val = {shreg[TOT_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      shreg <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (arm) armed <= 1'b1;
      if (armed && sck_rise) begin
        shreg <= {shreg[TOT_W-2:0], sdi};
        if (cnt == LAST) begin
          cnt   <= '0;
          armed <= 1'b0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rtcs_shift_out.sv
module rtcs_shift_out #(
  parameter int TOT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             grab,
  input  logic             sck_fall,
  input  logic [TOT_W-1:0] cur_time,
  output logic             sdo
);
  logic [TOT_W-1:0] snap;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      snap   <= '0;
      active <= 1'b0;
      sdo    <= 1'b0;
    end else if (grab) begin
      snap   <= cur_time;
      active <= 1'b1;
      sdo    <= cur_time[TOT_W-1];
    end else if (active && sck_fall) begin
      snap <= {snap[TOT_W-2:0], 1'b0};
      sdo  <= snap[TOT_W-2];
    end
  end
endmodule

// File: rtl/serial_time_counter.sv
module serial_time_counter #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int TOT_W = SEC_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_en_i,
  input  logic             wr_en_i,
  input  logic             cs_n_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_write_i,
  output logic [TOT_W-1:0] time_o,
  output logic             sdo_o
);
  import rtcs_pkg::*;

  logic [2:0]       pins_s;
  logic             cs_n_s, sck_s, sdi_s, sck_prev;
  logic             sel, sck_rise, sck_fall;
  logic             wr_commit;
  logic [TOT_W-1:0] wr_val;
  burst_kind_e      kind;
  logic             arm_wr, arm_rd;

  rtcs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n_i, sck_i, sdi_i}), .q(pins_s)
  );

  assign {cs_n_s, sck_s, sdi_s} = pins_s;
  assign sel = !cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  assign sck_rise = sck_s && !sck_prev;
  assign sck_fall = !sck_s && sck_prev;

  assign kind   = kind_of(cmd_write_i);
  assign arm_wr = cmd_valid_i && sel && (kind == BURST_WRITE);
  assign arm_rd = cmd_valid_i && sel && (kind == BURST_READ);

  rtcs_shift_in #(.TOT_W(TOT_W)) u_wr (
    .clk(clk), .rst(rst), .sel(sel), .arm(arm_wr), .sck_rise(sck_rise),
    .sdi(sdi_s), .wr_en(wr_en_i), .commit(wr_commit), .commit_val(wr_val)
  );

  rtcs_counter #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cnt (
    .clk(clk), .rst(rst), .run_en(run_en_i), .tick(tick_i),
    .load(wr_commit), .load_val(wr_val), .value(time_o)
  );

  rtcs_shift_out #(.TOT_W(TOT_W)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .grab(arm_rd), .sck_fall(sck_fall),
    .cur_time(time_o), .sdo(sdo_o)
  );
endmodule

// File: rtl/serial_time_counter_chk.sv
module serial_time_counter_chk #(
  parameter int TOT_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run_en,
  input logic             wr_en,
  input logic             sel,
  input logic             commit,
  input logic [TOT_W-1:0] commit_val,
  input logic [TOT_W-1:0] time_q,
  input logic             sdo
);
  // R2
  advance_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && tick && !commit) |=> time_q == $past(time_q) + TOT_W'(1));

  // R3
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !commit) |=> $stable(time_q));

  // R4
  commit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> wr_en);

  // R6
  no_commit_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |-> !commit);

  // R8
  sdo_quiet_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !sdo);

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> time_q == $past(commit_val));
endmodule

bind serial_time_counter serial_time_counter_chk #(.TOT_W(TOT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_i), .run_en(run_en_i), .wr_en(wr_en_i),
  .sel(sel), .commit(wr_commit), .commit_val(wr_val), .time_q(time_o),
  .sdo(sdo_o)
);

// File: tb/test_serial_time_counter.sv
module test_serial_time_counter;
  localparam int TW = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, run_en_i = 1'b0, wr_en_i = 1'b0;
  logic cs_n_i = 1'b1, sck_i = 1'b0, sdi_i = 1'b0;
  logic cmd_valid_i = 1'b0, cmd_write_i = 1'b0;
  logic [TW-1:0] time_o;
  logic sdo_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [TW-1:0] exp_t;

  always #2.5 clk = ~clk;

  serial_time_counter i_serial_time_counter (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_en_i(run_en_i),
    .wr_en_i(wr_en_i), .cs_n_i(cs_n_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .cmd_valid_i(cmd_valid_i), .cmd_write_i(cmd_write_i),
    .time_o(time_o), .sdo_o(sdo_o)
  );

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick_i = 1'b1; waitn(1); tick_i = 1'b0; waitn(1);
    if (run_en_i) exp_t = exp_t + TW'(1);
  endtask

  task automatic open_burst(input logic wr);
    cs_n_i = 1'b0; waitn(5);
    cmd_valid_i = 1'b1; cmd_write_i = wr; waitn(1);
    cmd_valid_i = 1'b0; waitn(2);
  endtask

  task automatic close_burst();
    cs_n_i = 1'b1; sck_i = 1'b0; waitn(6);
  endtask

  task automatic send_bit(input logic b);
    sdi_i = b; waitn(4);
    sck_i = 1'b1; waitn(8);
    sck_i = 1'b0; waitn(8);
  endtask

  task automatic write_bits(input logic [TW-1:0] v, input int nbits);
    open_burst(1'b1);
    for (int i = TW - 1; i >= TW - nbits; i--) send_bit(v[i]);
    close_burst();
  endtask

  task automatic read_bits(input int nbits, output logic [TW-1:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      got = {got[TW-2:0], sdo_o};
      sck_i = 1'b1; waitn(8);
      sck_i = 1'b0; waitn(8);
    end
  endtask

  task automatic t_reset();
    check("R1 time after reset", time_o, '0);
    check("R1 sdo after reset", TW'(sdo_o), '0);
  endtask

  task automatic t_count();
    run_en_i = 1'b1;
    for (int i = 0; i < 3; i++) pulse_tick();
    check("R2 three ticks", time_o, exp_t);
    run_en_i = 1'b0;
    for (int i = 0; i < 2; i++) pulse_tick();
    check("R3 ticks while stopped", time_o, exp_t);
  endtask

  task automatic t_write();
    wr_en_i = 1'b1;
    write_bits(40'h12_3456_789A, TW); exp_t = 40'h12_3456_789A;
    check("R5 full write loads value", time_o, exp_t);
    write_bits(40'hA5_0F0F_C3E1, TW); exp_t = 40'hA5_0F0F_C3E1;
    check("R5 second write pattern", time_o, exp_t);
  endtask

  task automatic t_wrap();
    wr_en_i = 1'b1;
    write_bits({32'h0000_0005, 8'hFF}, TW); exp_t = {32'h0000_0005, 8'hFF};
    run_en_i = 1'b1; pulse_tick();
    check("R2 fraction carry into seconds", time_o, {32'h0000_0006, 8'h00});
    run_en_i = 1'b0;
    write_bits({TW{1'b1}}, TW); exp_t = {TW{1'b1}};
    run_en_i = 1'b1; pulse_tick();
    check("R2 full rollover", time_o, '0);
    run_en_i = 1'b0;
  endtask

  task automatic t_wr_blocked();
    wr_en_i = 1'b0;
    write_bits(40'hAA_5555_AAAA, TW);
    check("R4 write ignored without enable", time_o, exp_t);
    wr_en_i = 1'b1;
  endtask

  task automatic t_abort();
    wr_en_i = 1'b1;
    write_bits(40'hFF_FFFF_FFFF, 20);
    check("R6 partial write discarded", time_o, exp_t);
    write_bits(40'h0F_1E2D_3C4B, 39);
    check("R6 39-bit write discarded", time_o, exp_t);
    write_bits(40'h0F_1E2D_3C4B, TW); exp_t = 40'h0F_1E2D_3C4B;
    check("R6 next burst restarts at bit 39", time_o, exp_t);
  endtask

  task automatic t_write_with_ticks();
    logic [TW-1:0] v = 40'h33_4455_6670;
    wr_en_i = 1'b1; run_en_i = 1'b1;
    open_burst(1'b1);
    for (int i = TW - 1; i >= 30; i--) send_bit(v[i]);
    pulse_tick(); pulse_tick();
    check("R10 counting during write burst", time_o, exp_t);
    for (int i = 29; i >= 0; i--) send_bit(v[i]);
    close_burst(); exp_t = v;
    check("R5 write commits over running count", time_o, exp_t);
    run_en_i = 1'b0;
  endtask

  task automatic t_read();
    logic [TW-1:0] snap_v, got, head, tail;
    run_en_i = 1'b1;
    snap_v = exp_t;
    open_burst(1'b0);
    read_bits(6, head);
    for (int i = 0; i < 3; i++) pulse_tick();
    read_bits(34, tail);
    got = (head << 34) | tail;
    check("R7 read returns snapshot", got, snap_v);
    check("R10 counter ran during read", time_o, exp_t);
    close_burst();
    run_en_i = 1'b0;
  endtask

  task automatic t_read_abort();
    logic [TW-1:0] got;
    logic [TW-1:0] snap_v = exp_t;
    open_burst(1'b0);
    read_bits(12, got);
    close_burst();
    check("R8 early bits valid", got, TW'(snap_v[TW-1:TW-12]));
    check("R8 sdo low after abort", TW'(sdo_o), '0);
    check("R8 time unaffected by abort", time_o, exp_t);
  endtask

  task automatic t_collide();
    logic [TW-1:0] v = 40'h01_0203_0410;
    wr_en_i = 1'b1; run_en_i = 1'b1;
    open_burst(1'b1);
    for (int i = TW - 1; i >= 1; i--) send_bit(v[i]);
    sdi_i = v[0]; waitn(4);
    sck_i = 1'b1; waitn(2);
    tick_i = 1'b1; waitn(1);
    tick_i = 1'b0; waitn(5);
    sck_i = 1'b0; waitn(8);
    close_burst(); exp_t = v;
    check("R9 written value wins over tick", time_o, exp_t);
    run_en_i = 1'b0;
  endtask

  initial begin
    exp_t = '0;
    waitn(4); rst = 1'b0; waitn(2);
    t_reset();
    t_count();
    t_write();
    t_wrap();
    t_wr_blocked();
    t_abort();
    t_write_with_ticks();
    t_read();
    t_read_abort();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule